// File: doc/BRIEF.md
# Match and Capture Timer

A 32-bit timer peripheral behind a small register bus. A programmable prescaler divides the system clock, and each time the prescaler wraps the main counter advances by one. Four compare channels watch the counter. On a hit, each channel can raise a flag, return the counter to zero, halt counting, and change the level of its own output pin. Four capture pins each pass through a two-flop synchroniser. A chosen edge on a pin copies the live counter value into that channel's capture register and can raise a flag.

Software drives the block through one request port with a valid/ready handshake. `bus_ready` is always high, so a request is accepted in the cycle `bus_valid` is seen. A read returns its data one cycle later with `rd_valid`. The response cannot be back-pressured and must be taken in that cycle. All flags are gathered in one status word, and `irq_o` is high while any flag is set.

Top module: `tmr_match_capture`

Word addresses: 0 flags, 1 control, 2 counter, 3 prescale limit, 4 prescale count, 5 compare configuration, 6 capture configuration, 7 pin control, 8 to 11 compare values 0 to 3, 12 to 15 capture values 0 to 3.

## Requirements
- R1: After reset every register reads 0, and `ext_o` and `irq_o` are low.
- R2: With control bit 0 set, the prescale count steps by one per clock. When it reaches the prescale limit it wraps to 0 and the counter advances by one, so after S enabled clocks from zero with limit P the counter reads S/(P+1) and the prescale count reads S mod (P+1).
- R3: While control bit 1 is set, the counter and the prescale count are held at 0, even if bit 0 is also set.
- R4: Compare channel n hits on a prescaler wrap while the counter equals its compare value. If configuration bit 3n is set, the hit sets flag bit n.
- R5: On a hit with configuration bit 3n+1 set, the counter goes to 0 instead of advancing, giving a period of value+1 counts.
- R6: On a hit with configuration bit 3n+2 set, control bit 0 clears. The counter keeps the compare value, unless bit 3n+1 is also set, in which case it goes to 0.
- R7: Capture channel n loads the counter on a rising edge when capture configuration bit 3n is set, and on a falling edge when bit 3n+1 is set. A load with bit 3n+2 set raises flag bit 4+n. Edges that are not selected load nothing.
- R8: Writing the flags word clears each bit written as 1 and leaves bits written as 0 unchanged. A flag set by an event in the same cycle as its clear stays set.
- R9: Pin control bits 0 to 3 hold the `ext_o` levels and can be written. The 2-bit code at bits 4+2n and 5+2n selects the action on a hit of channel n: 0 keep, 1 drive low, 2 drive high, 3 toggle.
- R10: `irq_o` is high exactly when any flag bit is set.
- R11: `bus_ready` is always high. A read accepted in one cycle gives `rd_valid` high with its data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request ready, always high |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| cap_i | input | 4 | Capture pins |
| ext_o | output | 4 | Compare output pins |
| irq_o | output | 1 | Any flag set |

## Verification
Two things can land in the same cycle: a software clear of a flag and the hardware event that sets that flag. The bench toggles a capture pin and then counts the synchroniser stages, so that its write-one-to-clear of the capture flag reaches the register on the same edge as the capture. It then expects the flag to read back as set. A second overlap is a halting compare hit against a control write. Here the hit must win, and this is judged by reading back the control word and the frozen counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } pin_act_e;

  localparam int A_FLAGS  = 0;
  localparam int A_CTRL   = 1;
  localparam int A_COUNT  = 2;
  localparam int A_PLIM   = 3;
  localparam int A_PCNT   = 4;
  localparam int A_MCFG   = 5;
  localparam int A_CCFG   = 6;
  localparam int A_PINS   = 7;
  localparam int A_MATCH0 = 8;

  function automatic logic pin_apply(pin_act_e act, logic cur);
    case (act)
      PIN_LOW:    return 1'b0;
      PIN_HIGH:   return 1'b1;
      PIN_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale_count.sv
module tmr_prescale_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         hold,
  input  logic         clr_req,
  input  logic         halt_req,
  input  logic [W-1:0] plimit,
  output logic         tick,
  output logic [W-1:0] tc,
  output logic [W-1:0] pc
);
  logic [W-1:0] tc_q, pc_q;

  assign tick = run & ~hold & (pc_q >= plimit);
  assign tc   = tc_q;
  assign pc   = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (hold) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (run) begin
      if (tick) begin
        pc_q <= '0;
        if (clr_req)        tc_q <= '0;
        else if (!halt_req) tc_q <= tc_q + 1'b1;
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         tick,
  input  logic [W-1:0] tc,
  input  logic [W-1:0] mval,
  input  logic [2:0]   cfg,
  input  logic [1:0]   act,
  input  logic         lvl,
  output logic         flag_set,
  output logic         clr,
  output logic         stop,
  output logic         lvl_nxt
);
  logic hit;

  assign hit      = tick & (tc == mval);
  assign flag_set = hit & cfg[0];
  assign clr      = hit & cfg[1];
  assign stop     = hit & cfg[2];
  assign lvl_nxt  = hit ? pin_apply(pin_act_e'(act), lvl) : lvl;
endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  logic [W-1:0] tc,
  input  logic [2:0]   cfg,
  output logic [W-1:0] val,
  output logic         flag_set
);
  logic s1_q, s2_q, prev_q;
  logic rise, fall, load;

  assign rise     = s2_q & ~prev_q;
  assign fall     = ~s2_q & prev_q;
  assign load     = (rise & cfg[0]) | (fall & cfg[1]);
  assign flag_set = load & cfg[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      val    <= '0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (load) val <= tc;
    end
  end
endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAPT  = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CNT_W-1:0]    bus_wdata,
  output logic                rd_valid,
  output logic [CNT_W-1:0]    rd_data,
  input  logic [N_CAPT-1:0]   cap_i,
  output logic [N_MATCH-1:0]  ext_o,
  output logic                irq_o
);
  localparam int MCFG_W = 3 * N_MATCH;
  localparam int CCFG_W = 3 * N_CAPT;
  localparam int FLG_W  = N_MATCH + N_CAPT;
  localparam int ACT_W  = 2 * N_MATCH;
  localparam int PINS_W = N_MATCH + ACT_W;
  localparam int A_CAPT0 = A_MATCH0 + N_MATCH;

  localparam logic [ADDR_W-1:0] AD_FLAGS = ADDR_W'(A_FLAGS);
  localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_COUNT = ADDR_W'(A_COUNT);
  localparam logic [ADDR_W-1:0] AD_PLIM  = ADDR_W'(A_PLIM);
  localparam logic [ADDR_W-1:0] AD_PCNT  = ADDR_W'(A_PCNT);
  localparam logic [ADDR_W-1:0] AD_MCFG  = ADDR_W'(A_MCFG);
  localparam logic [ADDR_W-1:0] AD_CCFG  = ADDR_W'(A_CCFG);
  localparam logic [ADDR_W-1:0] AD_PINS  = ADDR_W'(A_PINS);

  logic [1:0]          ctrl_q;
  logic [CNT_W-1:0]    plim_q;
  logic [MCFG_W-1:0]   mcfg_q;
  logic [CCFG_W-1:0]   ccfg_q;
  logic [N_MATCH-1:0]  lvl_q;
  logic [ACT_W-1:0]    act_q;
  logic [FLG_W-1:0]    flags_q;
  logic [CNT_W-1:0]    match_q [N_MATCH];
  logic [CNT_W-1:0]    capt_w  [N_CAPT];

  logic                tick;
  logic [CNT_W-1:0]    tc_w, pc_w;
  logic [N_MATCH-1:0]  m_flag, m_clr, m_stop, lvl_nxt;
  logic [N_CAPT-1:0]   c_flag;
  logic                any_clr, any_stop;
  logic                wr, rd;
  logic [CNT_W-1:0]    rd_mux;

  assign bus_ready = 1'b1;
  assign wr        = bus_valid & bus_write;
  assign rd        = bus_valid & ~bus_write;
  assign any_clr   = |m_clr;
  assign any_stop  = |m_stop;
  assign ext_o     = lvl_q;
  assign irq_o     = |flags_q;

  tmr_prescale_count #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q[0]),
    .hold     (ctrl_q[1]),
    .clr_req  (any_clr),
    .halt_req (any_stop),
    .plimit   (plim_q),
    .tick     (tick),
    .tc       (tc_w),
    .pc       (pc_w)
  );

  for (genvar g = 0; g < N_MATCH; g++) begin : g_match
    tmr_match_chan #(.W(CNT_W)) u_m (
      .tick     (tick),
      .tc       (tc_w),
      .mval     (match_q[g]),
      .cfg      (mcfg_q[3*g +: 3]),
      .act      (act_q[2*g +: 2]),
      .lvl      (lvl_q[g]),
      .flag_set (m_flag[g]),
      .clr      (m_clr[g]),
      .stop     (m_stop[g]),
      .lvl_nxt  (lvl_nxt[g])
    );
  end

  for (genvar g = 0; g < N_CAPT; g++) begin : g_capt
    tmr_capture_chan #(.W(CNT_W)) u_c (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (cap_i[g]),
      .tc       (tc_w),
      .cfg      (ccfg_q[3*g +: 3]),
      .val      (capt_w[g]),
      .flag_set (c_flag[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      plim_q  <= '0;
      mcfg_q  <= '0;
      ccfg_q  <= '0;
      lvl_q   <= '0;
      act_q   <= '0;
      flags_q <= '0;
      for (int i = 0; i < N_MATCH; i++) match_q[i] <= '0;
    end else begin
      if (wr && bus_addr == AD_CTRL) ctrl_q <= bus_wdata[1:0];
      if (any_stop)                  ctrl_q[0] <= 1'b0;
      if (wr && bus_addr == AD_PLIM) plim_q <= bus_wdata;
      if (wr && bus_addr == AD_MCFG) mcfg_q <= bus_wdata[MCFG_W-1:0];
      if (wr && bus_addr == AD_CCFG) ccfg_q <= bus_wdata[CCFG_W-1:0];
      if (wr && bus_addr == AD_PINS) begin
        lvl_q <= bus_wdata[N_MATCH-1:0];
        act_q <= bus_wdata[PINS_W-1:N_MATCH];
      end
      for (int i = 0; i < N_MATCH; i++) begin
        if (m_clr[i] | m_stop[i] | m_flag[i] | (lvl_nxt[i] != lvl_q[i]))
          lvl_q[i] <= lvl_nxt[i];
        if (wr && bus_addr == ADDR_W'(A_MATCH0 + i)) match_q[i] <= bus_wdata;
      end
      flags_q <= (flags_q & ~((wr && bus_addr == AD_FLAGS) ? bus_wdata[FLG_W-1:0] : '0))
                 | {c_flag, m_flag};
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AD_FLAGS) rd_mux = CNT_W'(flags_q);
    if (bus_addr == AD_CTRL)  rd_mux = CNT_W'(ctrl_q);
    if (bus_addr == AD_COUNT) rd_mux = tc_w;
    if (bus_addr == AD_PLIM)  rd_mux = plim_q;
    if (bus_addr == AD_PCNT)  rd_mux = pc_w;
    if (bus_addr == AD_MCFG)  rd_mux = CNT_W'(mcfg_q);
    if (bus_addr == AD_CCFG)  rd_mux = CNT_W'(ccfg_q);
    if (bus_addr == AD_PINS)  rd_mux = CNT_W'({act_q, lvl_q});
    for (int i = 0; i < N_MATCH; i++)
      if (bus_addr == ADDR_W'(A_MATCH0 + i)) rd_mux = match_q[i];
    for (int i = 0; i < N_CAPT; i++)
      if (bus_addr == ADDR_W'(A_CAPT0 + i)) rd_mux = capt_w[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/tmr_mc_checker.sv
module tmr_mc_checker #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAPT  = 4,
  parameter int ADDR_W  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_valid,
  input logic                      bus_write,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [N_MATCH+N_CAPT-1:0] wdata_lo,
  input logic                      rd_valid,
  input logic                      run,
  input logic                      hold,
  input logic [CNT_W-1:0]          tc,
  input logic [CNT_W-1:0]          pc,
  input logic [N_MATCH+N_CAPT-1:0] flags,
  input logic                      any_stop,
  input logic                      any_clr
);
  localparam int FLG_W = N_MATCH + N_CAPT;
  logic [FLG_W-1:0] clr_mask;

  assign clr_mask = (bus_valid && bus_write && bus_addr == ADDR_W'(0)) ? wdata_lo : '0;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tc == $past(tc) || tc == $past(tc) + 1'b1 || tc == '0))
    else $error("counter jumped");

  p_hold_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (tc == '0 && pc == '0))
    else $error("hold did not clear");

  p_clear_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_clr |=> (tc == '0))
    else $error("match clear missed");

  p_stop_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_stop |=> !run)
    else $error("match stop missed");

  p_flag_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flags & $past(flags) & ~$past(clr_mask)) == '0))
    else $error("flag dropped without clear");

  p_rd_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid)
    else $error("read response missing");
endmodule

bind tmr_match_capture tmr_mc_checker #(
  .CNT_W(CNT_W), .N_MATCH(N_MATCH), .N_CAPT(N_CAPT), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .wdata_lo  (bus_wdata[N_MATCH+N_CAPT-1:0]),
  .rd_valid  (rd_valid),
  .run       (ctrl_q[0]),
  .hold      (ctrl_q[1]),
  .tc        (tc_w),
  .pc        (pc_w),
  .flags     (flags_q),
  .any_stop  (any_stop),
  .any_clr   (any_clr)
);

// File: tb/sim_tmr_match_capture.sv
`timescale 1ns/1ps
module sim_tmr_match_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, rd_valid, irq_o;
  logic [31:0] rd_data;
  logic [3:0]  cap_i = '0;
  logic [3:0]  ext_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_match_capture u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .cap_i(cap_i), .ext_o(ext_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input int a, input string tag, input logic [31:0] exp);
    bus_valid = 1; bus_write = 0; bus_addr = 4'(a);
    chk("R11 ready", 32'(bus_ready), 32'd1);
    @(negedge clk);
    bus_valid = 0;
    chk("R11 rd_valid", 32'(rd_valid), 32'd1);
    chk(tag, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] steps_count(int s, int p);
    return 32'(s / (p + 1));
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle(4);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd(0, "R1 flags", 0);
    rd(1, "R1 ctrl", 0);
    rd(2, "R1 count", 0);
    rd(7, "R1 pins", 0);
    rd(12, "R1 capt0", 0);
    chk("R1 ext_o", 32'(ext_o), 0);
    chk("R1 irq", 32'(irq_o), 0);

    // R2 random prescale runs
    for (int it = 0; it < 6; it++) begin
      int p, k;
      p = int'($urandom % 4);
      k = 3 + int'($urandom % 30);
      wr(3, 32'(p));
      wr(1, 32'd2);
      wr(1, 32'd1);
      idle(k);
      wr(1, 32'd0);
      rd(2, "R2 count", steps_count(k + 1, p));
      rd(4, "R2 prescale", 32'((k + 1) % (p + 1)));
    end

    // R3 hold dominates enable
    wr(1, 32'd3);
    idle(5);
    rd(2, "R3 count", 0);
    rd(4, "R3 prescale", 0);
    wr(1, 32'd0);

    // R4 R5 R9 clear on match with toggle action
    begin
      int k, s;
      k = 12 + int'($urandom % 29);
      s = k + 1;
      wr(3, 0);
      wr(8, 5);
      wr(5, 32'h3);
      wr(7, 32'h30);
      wr(1, 32'd2);
      wr(1, 32'd1);
      idle(k);
      wr(1, 32'd0);
      rd(2, "R5 count wraps", 32'(s % 6));
      rd(0, "R4 match flag", 32'h1);
      chk("R9 toggle", 32'(ext_o[0]), 32'((s / 6) & 1));
      chk("R10 irq set", 32'(irq_o), 1);
    end

    // R8 write-one-to-clear
    wr(0, 32'h0);
    rd(0, "R8 zero keeps", 32'h1);
    wr(0, 32'h1);
    rd(0, "R8 one clears", 32'h0);
    chk("R10 irq clear", 32'(irq_o), 0);

    // R6 stop without clear, R9 drive high
    wr(5, 32'h28);
    wr(9, 7);
    wr(3, 1);
    wr(7, 32'h80);
    wr(1, 32'd2);
    wr(1, 32'd1);
    idle(40);
    rd(1, "R6 enable cleared", 0);
    rd(2, "R6 count frozen", 7);
    rd(0, "R4 ch1 flag", 32'h2);
    chk("R9 drive high", 32'(ext_o), 32'h2);

    // R7 capture rising, edge selection
    wr(0, 32'hFF);
    wr(6, 32'h8D5);
    cap_i = 4'hF;
    idle(4);
    rd(12, "R7 rise ch0", 7);
    rd(13, "R7 fall-only ch1 ignores rise", 0);
    rd(14, "R7 both ch2", 7);
    rd(15, "R7 none ch3", 0);
    rd(0, "R7 capture flag", 32'h10);

    // move counter to 11, then falling edge
    wr(5, 32'h800);
    wr(11, 11);
    wr(1, 32'd1);
    idle(40);
    rd(2, "R6 count at 11", 11);
    cap_i = 4'h0;
    idle(4);
    rd(12, "R7 rise-only ch0 keeps", 7);
    rd(13, "R7 fall ch1", 11);
    rd(14, "R7 both ch2 fall", 11);
    rd(15, "R7 none ch3 fall", 0);

    // R6 clear plus stop, R9 drive low
    wr(5, 32'h180);
    wr(10, 13);
    wr(7, 32'h106);
    wr(1, 32'd1);
    idle(40);
    rd(2, "R6 clear+stop count", 0);
    rd(1, "R6 clear+stop enable", 0);
    chk("R9 drive low keeps others", 32'(ext_o), 32'h2);

    // R8 clear and capture event on the same edge
    wr(0, 32'hFF);
    cap_i = 4'h1;
    idle(2);
    wr(0, 32'h10);
    rd(0, "R8 set wins", 32'h10);
    wr(0, 32'h10);
    rd(0, "R8 later clear", 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule